// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block manages a small direct-mapped write-back cache that stays coherent with its peers on a shared, atomic bus. Every line carries one of three states: Modified (the only valid copy, dirty), Shared (clean, possibly held elsewhere) or Invalid. Processor reads and writes are served locally when the line state allows it. Otherwise the controller requests the bus and issues a shared read or an exclusive read. When it must evict a dirty line, it first writes that line back.

The same controller watches every transaction that other caches put on the bus. A snooped shared read to a Modified line makes it drive its data onto the bus, and the line drops to Shared. A snooped exclusive read to a Modified line also drives the data, and the line drops to Invalid. A snooped exclusive read to a Shared line invalidates it silently. The bus model outside the block grants one master at a time, routes the granted transaction to every other cache's snoop port, and completes it in the granted cycle. The fill data comes from a flushing cache if one responds, and from memory otherwise.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and `bus_req` and `flush_valid` are low.
- R2: A processor read or write that hits a Modified line completes without any bus transaction. The line stays Modified and keeps the written value.
- R3: A read that hits a Shared line completes without a bus transaction. A write that hits a Shared line issues an exclusive read (`bus_cmd` = 1), after which the line is Modified.
- R4: A read that misses issues a shared read (`bus_cmd` = 0) and leaves the line Shared with the returned data. A write that misses issues an exclusive read and leaves the line Modified holding the written value.
- R5: A snooped shared read (`snp_cmd` = 0) to a Modified line raises `flush_valid` with the line data in that same cycle, and the line becomes Shared.
- R6: A snooped exclusive read (`snp_cmd` = 1) to a Modified line raises `flush_valid` with the line data in that same cycle, and the line becomes Invalid.
- R7: A snooped exclusive read to a Shared line invalidates it without a flush. A snooped shared read to a Shared line leaves it Shared.
- R8: A snoop to an index whose line is Invalid, or whose tag differs from the snooped address, raises no flush and changes no line.
- R9: A miss whose victim line is Modified first issues a write-back (`bus_cmd` = 2) carrying the victim's address and data. After that it issues the fill, and the victim is no longer held.
- R10: With the bus granted at once, a response arrives 2 clock edges after the accepting edge on a hit, 3 on a miss and 4 on a miss that needs a write-back.
- R11: A transaction completes in the cycle `bus_gnt` is high, and the fill takes `bus_rdata` from that cycle. The snoop port is never active while this controller is granted.
- R12: With two controllers on one bus, every processor read returns the last value written to that address by either processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Word address of the request |
| cpu_req_wdata | input | DW | Write data |
| cpu_req_ready | output | 1 | Controller idle, request accepted on this edge |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DW | Line data at completion |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 shared read, 1 exclusive read, 2 write-back, 3 none |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write-back data |
| bus_gnt | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DW | Fill data in the granted cycle |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | AW | Address of the snooped transaction |
| flush_valid | output | 1 | This cache supplies dirty data now |
| flush_data | output | DW | Supplied line data |

## Verification
The bench goes after ownership hand-offs between two caches on the same address. If a shared read were confused with an exclusive read on the Modified side, the former owner would miss where it should hit, or would keep a dirty copy, and the next read would return stale data. Silent upgrades from Shared are checked through the peer's next access. A controller that wrote without an exclusive read would leave the other cache returning an old value. Conflict misses on a dirty victim are checked for the write-back order and address. A design that filled first or dropped the write-back would lose the value, and the peer would later read memory's old copy. Concurrent requests to lines sharing an index check that a snoop landing during a lookup is not lost.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        BC_RD   = 2'd0,
        BC_RDX  = 2'd1,
        BC_WB   = 2'd2,
        BC_IDLE = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_TAG,
        CS_WB,
        CS_FILL,
        CS_RESP
    } ctrl_state_e;

    // State a line moves to when another master's transaction hits it.
    function automatic line_state_e snoop_next_state(line_state_e cur, bus_cmd_e cmd);
        line_state_e nxt;
        nxt = cur;
        case (cur)
            LS_M: begin
                if (cmd == BC_RD)       nxt = LS_S;
                else if (cmd == BC_RDX) nxt = LS_I;
            end
            LS_S: begin
                if (cmd == BC_RDX)      nxt = LS_I;
            end
            default: nxt = LS_I;
        endcase
        return nxt;
    endfunction

    // Dirty data must be supplied for any read-type snoop of an owned line.
    function automatic logic snoop_must_flush(line_state_e cur, bus_cmd_e cmd);
        return (cur == LS_M) && ((cmd == BC_RD) || (cmd == BC_RDX));
    endfunction

    function automatic bus_cmd_e miss_cmd(logic is_write);
        return is_write ? BC_RDX : BC_RD;
    endfunction

    function automatic line_state_e fill_state(logic is_write);
        return is_write ? LS_M : LS_S;
    endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    // processor-side lookup
    input  logic [IDX_W-1:0] p_idx,
    output line_state_e      p_state,
    output logic [TAG_W-1:0] p_tag,
    output logic [DW-1:0]    p_data,
    // snoop-side lookup and state update
    input  logic [IDX_W-1:0] s_idx,
    output line_state_e      s_state,
    output logic [TAG_W-1:0] s_tag,
    output logic [DW-1:0]    s_data,
    input  logic             s_we,
    input  line_state_e      s_new,
    // full-entry write from the request sequencer
    input  logic             w_en,
    input  logic [IDX_W-1:0] w_idx,
    input  line_state_e      w_state,
    input  logic [TAG_W-1:0] w_tag,
    input  logic [DW-1:0]    w_data
);

    localparam int LINES = 1 << IDX_W;

    line_state_e      st_arr  [LINES];
    logic [TAG_W-1:0] tag_arr [LINES];
    logic [DW-1:0]    dat_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_state_e      st_r;
        logic [TAG_W-1:0] tag_r;
        logic [DW-1:0]    dat_r;
        logic             w_hit;
        logic             s_hit;

        assign w_hit = w_en && (w_idx == IDX_W'(g));
        assign s_hit = s_we && (s_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r  <= LS_I;
                tag_r <= '0;
                dat_r <= '0;
            end else if (w_hit) begin
                st_r  <= w_state;
                tag_r <= w_tag;
                dat_r <= w_data;
            end else if (s_hit) begin
                st_r  <= s_new;
            end
        end

        assign st_arr[g]  = st_r;
        assign tag_arr[g] = tag_r;
        assign dat_arr[g] = dat_r;
    end

    assign p_state = st_arr[p_idx];
    assign p_tag   = tag_arr[p_idx];
    assign p_data  = dat_arr[p_idx];
    assign s_state = st_arr[s_idx];
    assign s_tag   = tag_arr[s_idx];
    assign s_data  = dat_arr[s_idx];

    logic [IDX_W-1:0] chk_sidx_q;
    always_ff @(posedge clk) chk_sidx_q <= s_idx;

    // R11
    wr_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (w_en && s_we) |-> (w_idx != s_idx));

    // R6
    snoop_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (s_we && (s_new == LS_I)) |=> (st_arr[chk_sidx_q] == LS_I));

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int AW    = 6,
    parameter int IDX_W = 2,
    parameter int DW    = 16
) (
    input  logic                snp_valid,
    input  bus_cmd_e            snp_cmd,
    input  logic [AW-1:0]       snp_addr,
    output logic [IDX_W-1:0]    s_idx,
    input  line_state_e         s_state,
    input  logic [AW-IDX_W-1:0] s_tag,
    input  logic [DW-1:0]       s_data,
    output logic                s_we,
    output line_state_e         s_new,
    output logic                flush_valid,
    output logic [DW-1:0]       flush_data
);

    localparam int TAG_W = AW - IDX_W;

    logic [TAG_W-1:0] snp_tag;
    logic             present;

    assign s_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[AW-1:IDX_W];
    assign present = snp_valid && (s_state != LS_I) && (s_tag == snp_tag);

    assign s_new       = snoop_next_state(s_state, snp_cmd);
    assign s_we        = present && (s_new != s_state);
    assign flush_valid = present && snoop_must_flush(s_state, snp_cmd);
    assign flush_data  = flush_valid ? s_data : '0;

endmodule

// File: rtl/msi_proc_fsm.sv
module msi_proc_fsm
    import msi_pkg::*;
#(
    parameter int AW    = 6,
    parameter int IDX_W = 2,
    parameter int DW    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_req_valid,
    input  logic                cpu_req_write,
    input  logic [AW-1:0]       cpu_req_addr,
    input  logic [DW-1:0]       cpu_req_wdata,
    output logic                cpu_req_ready,
    output logic                cpu_resp_valid,
    output logic [DW-1:0]       cpu_resp_rdata,
    output logic                bus_req,
    output bus_cmd_e            bus_cmd,
    output logic [AW-1:0]       bus_addr,
    output logic [DW-1:0]       bus_wdata,
    input  logic                bus_gnt,
    input  logic [DW-1:0]       bus_rdata,
    input  logic                snp_valid,
    input  logic [IDX_W-1:0]    snp_idx,
    output logic [IDX_W-1:0]    p_idx,
    input  line_state_e         p_state,
    input  logic [AW-IDX_W-1:0] p_tag,
    input  logic [DW-1:0]       p_data,
    output logic                w_en,
    output logic [IDX_W-1:0]    w_idx,
    output line_state_e         w_state,
    output logic [AW-IDX_W-1:0] w_tag,
    output logic [DW-1:0]       w_data
);

    localparam int TAG_W = AW - IDX_W;

    ctrl_state_e      st_q, st_d;
    logic             rq_write;
    logic [AW-1:0]    rq_addr;
    logic [DW-1:0]    rq_wdata;
    logic [TAG_W-1:0] victim_q;

    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             hit;
    logic             snoop_busy;
    logic             victim_live;

    assign req_idx     = rq_addr[IDX_W-1:0];
    assign req_tag     = rq_addr[AW-1:IDX_W];
    assign p_idx       = req_idx;
    assign hit         = (p_state != LS_I) && (p_tag == req_tag);
    assign snoop_busy  = snp_valid && (snp_idx == req_idx);
    assign victim_live = (p_state == LS_M) && (p_tag == victim_q);

    always_comb begin
        st_d      = st_q;
        w_en      = 1'b0;
        w_idx     = req_idx;
        w_state   = p_state;
        w_tag     = p_tag;
        w_data    = p_data;
        bus_req   = 1'b0;
        bus_cmd   = BC_IDLE;
        bus_addr  = rq_addr;
        bus_wdata = p_data;
        case (st_q)
            CS_IDLE: begin
                if (cpu_req_valid) st_d = CS_TAG;
            end
            CS_TAG: begin
                if (!snoop_busy) begin
                    if (hit && (p_state == LS_M)) begin
                        if (rq_write) begin
                            w_en   = 1'b1;
                            w_data = rq_wdata;
                        end
                        st_d = CS_RESP;
                    end else if (hit && !rq_write) begin
                        st_d = CS_RESP;
                    end else if (hit) begin
                        st_d = CS_FILL;
                    end else if (p_state == LS_M) begin
                        st_d = CS_WB;
                    end else begin
                        st_d = CS_FILL;
                    end
                end
            end
            CS_WB: begin
                if (victim_live) begin
                    bus_req  = 1'b1;
                    bus_cmd  = BC_WB;
                    bus_addr = {victim_q, req_idx};
                    if (bus_gnt) begin
                        w_en    = 1'b1;
                        w_state = LS_I;
                        st_d    = CS_FILL;
                    end
                end else begin
                    st_d = CS_FILL;
                end
            end
            CS_FILL: begin
                bus_req = 1'b1;
                bus_cmd = miss_cmd(rq_write);
                if (bus_gnt) begin
                    w_en    = 1'b1;
                    w_tag   = req_tag;
                    w_state = fill_state(rq_write);
                    w_data  = rq_write ? rq_wdata : bus_rdata;
                    st_d    = CS_RESP;
                end
            end
            CS_RESP: st_d = CS_IDLE;
            default: st_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= CS_IDLE;
            rq_write <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
            victim_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == CS_IDLE && cpu_req_valid) begin
                rq_write <= cpu_req_write;
                rq_addr  <= cpu_req_addr;
                rq_wdata <= cpu_req_wdata;
            end
            if (st_q == CS_TAG && st_d == CS_WB) victim_q <= p_tag;
        end
    end

    assign cpu_req_ready  = (st_q == CS_IDLE);
    assign cpu_resp_valid = (st_q == CS_RESP);
    assign cpu_resp_rdata = p_data;

    // R2
    resp_line_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CS_RESP) |-> ((p_state != LS_I) && (p_tag == req_tag)));

    // R4
    resp_write_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CS_RESP && rq_write) |-> (p_state == LS_M));

    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CS_TAG && !snoop_busy && hit && (p_state == LS_M || !rq_write))
        |=> !bus_req);

    // R9
    wb_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd == BC_WB && bus_gnt) |=> (p_state == LS_I));

endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int AW    = 6,
    parameter int IDX_W = 2,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req_valid,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_req_ready,
    output logic          cpu_resp_valid,
    output logic [DW-1:0] cpu_resp_rdata,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          flush_valid,
    output logic [DW-1:0] flush_data
);

    localparam int TAG_W = AW - IDX_W;

    logic [IDX_W-1:0] p_idx, s_idx, w_idx;
    line_state_e      p_state, s_state, w_state, s_new;
    logic [TAG_W-1:0] p_tag, s_tag, w_tag;
    logic [DW-1:0]    p_data, s_data, w_data;
    logic             s_we, w_en;
    bus_cmd_e         cmd_int;

    assign bus_cmd = cmd_int;

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .p_idx   (p_idx),
        .p_state (p_state),
        .p_tag   (p_tag),
        .p_data  (p_data),
        .s_idx   (s_idx),
        .s_state (s_state),
        .s_tag   (s_tag),
        .s_data  (s_data),
        .s_we    (s_we),
        .s_new   (s_new),
        .w_en    (w_en),
        .w_idx   (w_idx),
        .w_state (w_state),
        .w_tag   (w_tag),
        .w_data  (w_data)
    );

    msi_snoop_unit #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_cmd     (bus_cmd_e'(snp_cmd)),
        .snp_addr    (snp_addr),
        .s_idx       (s_idx),
        .s_state     (s_state),
        .s_tag       (s_tag),
        .s_data      (s_data),
        .s_we        (s_we),
        .s_new       (s_new),
        .flush_valid (flush_valid),
        .flush_data  (flush_data)
    );

    msi_proc_fsm #(.AW(AW), .IDX_W(IDX_W), .DW(DW)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .bus_req        (bus_req),
        .bus_cmd        (cmd_int),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_gnt        (bus_gnt),
        .bus_rdata      (bus_rdata),
        .snp_valid      (snp_valid),
        .snp_idx        (s_idx),
        .p_idx          (p_idx),
        .p_state        (p_state),
        .p_tag          (p_tag),
        .p_data         (p_data),
        .w_en           (w_en),
        .w_idx          (w_idx),
        .w_state        (w_state),
        .w_tag          (w_tag),
        .w_data         (w_data)
    );

    // R11
    atomic_bus_chk: assert property (@(posedge clk) disable iff (rst)
        bus_gnt |-> !snp_valid);

    // R5
    flush_owner_chk: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> (s_state != LS_M) || !snp_valid || (s_idx != $past(s_idx))
                        || (s_tag != $past(s_tag)));

endmodule

// File: tb/test_msi_cache_ctrl.sv
module test_msi_cache_ctrl;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NADDR = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          rq_v   [2];
    logic          rq_w   [2];
    logic [AW-1:0] rq_a   [2];
    logic [DW-1:0] rq_d   [2];
    logic          rdy    [2];
    logic          rsp_v  [2];
    logic [DW-1:0] rsp_d  [2];
    logic          breq   [2];
    logic [1:0]    bcmd   [2];
    logic [AW-1:0] baddr  [2];
    logic [DW-1:0] bwd    [2];
    logic          gnt    [2];
    logic [DW-1:0] brd    [2];
    logic          sv     [2];
    logic [1:0]    scmd   [2];
    logic [AW-1:0] saddr  [2];
    logic          fv     [2];
    logic [DW-1:0] fd     [2];

    logic [DW-1:0] mem [NADDR];
    logic [DW-1:0] gm  [NADDR];

    int n_rd [2], n_rdx [2], n_wb [2], n_fl [2];
    logic [DW-1:0] last_fl [2], last_wbd [2];
    logic [AW-1:0] last_wba [2];
    int wb_cyc [2], fill_cyc [2];
    int cyc;
    int n_chk = 0, n_err = 0;

    function automatic logic [DW-1:0] init_val(int a);
        return DW'(a * 37 + 11);
    endfunction

    // shared bus model: cache 0 wins, transaction completes in the grant cycle
    assign gnt[0]   = breq[0];
    assign gnt[1]   = breq[1] && !breq[0];
    assign sv[1]    = gnt[0];
    assign scmd[1]  = bcmd[0];
    assign saddr[1] = baddr[0];
    assign sv[0]    = gnt[1];
    assign scmd[0]  = bcmd[1];
    assign saddr[0] = baddr[1];
    assign brd[0]   = fv[1] ? fd[1] : mem[baddr[0]];
    assign brd[1]   = fv[0] ? fd[0] : mem[baddr[1]];

    msi_cache_ctrl #(.AW(AW), .IDX_W(2), .DW(DW)) i_msi_cache_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req_valid(rq_v[0]), .cpu_req_write(rq_w[0]), .cpu_req_addr(rq_a[0]),
        .cpu_req_wdata(rq_d[0]), .cpu_req_ready(rdy[0]), .cpu_resp_valid(rsp_v[0]),
        .cpu_resp_rdata(rsp_d[0]), .bus_req(breq[0]), .bus_cmd(bcmd[0]),
        .bus_addr(baddr[0]), .bus_wdata(bwd[0]), .bus_gnt(gnt[0]), .bus_rdata(brd[0]),
        .snp_valid(sv[0]), .snp_cmd(scmd[0]), .snp_addr(saddr[0]),
        .flush_valid(fv[0]), .flush_data(fd[0])
    );

    msi_cache_ctrl #(.AW(AW), .IDX_W(2), .DW(DW)) i_peer_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req_valid(rq_v[1]), .cpu_req_write(rq_w[1]), .cpu_req_addr(rq_a[1]),
        .cpu_req_wdata(rq_d[1]), .cpu_req_ready(rdy[1]), .cpu_resp_valid(rsp_v[1]),
        .cpu_resp_rdata(rsp_d[1]), .bus_req(breq[1]), .bus_cmd(bcmd[1]),
        .bus_addr(baddr[1]), .bus_wdata(bwd[1]), .bus_gnt(gnt[1]), .bus_rdata(brd[1]),
        .snp_valid(sv[1]), .snp_cmd(scmd[1]), .snp_addr(saddr[1]),
        .flush_valid(fv[1]), .flush_data(fd[1])
    );

    // memory and bus monitor
    always @(posedge clk) begin
        if (rst) begin
            cyc <= 0;
            for (int a = 0; a < NADDR; a++) mem[a] <= init_val(a);
            for (int c = 0; c < 2; c++) begin
                n_rd[c] <= 0; n_rdx[c] <= 0; n_wb[c] <= 0; n_fl[c] <= 0;
                last_fl[c] <= '0; last_wbd[c] <= '0; last_wba[c] <= '0;
                wb_cyc[c] <= 0; fill_cyc[c] <= 0;
            end
        end else begin
            cyc <= cyc + 1;
            for (int c = 0; c < 2; c++) begin
                if (gnt[c]) begin
                    if (bcmd[c] == 2'd0) begin
                        n_rd[c] <= n_rd[c] + 1; fill_cyc[c] <= cyc;
                    end else if (bcmd[c] == 2'd1) begin
                        n_rdx[c] <= n_rdx[c] + 1; fill_cyc[c] <= cyc;
                    end else if (bcmd[c] == 2'd2) begin
                        n_wb[c] <= n_wb[c] + 1; wb_cyc[c] <= cyc;
                        last_wba[c] <= baddr[c]; last_wbd[c] <= bwd[c];
                        mem[baddr[c]] <= bwd[c];
                    end
                    if (fv[1-c]) begin
                        n_fl[1-c] <= n_fl[1-c] + 1;
                        last_fl[1-c] <= fd[1-c];
                        mem[baddr[c]] <= fd[1-c];
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_op(input int c, input logic wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                          output int lat);
        @(negedge clk);
        rq_v[c] = 1'b1; rq_w[c] = wr; rq_a[c] = a; rq_d[c] = wd;
        while (!rdy[c]) @(negedge clk);
        @(negedge clk);
        rq_v[c] = 1'b0;
        lat = 1;
        while (!rsp_v[c]) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_d[c];
    endtask

    task automatic run(input int c, input logic wr, input int a, input logic [DW-1:0] wd,
                       input logic [DW-1:0] exp_rd, input int exp_lat, input string req);
        logic [DW-1:0] rd;
        int lat;
        cpu_op(c, wr, AW'(a), wd, rd, lat);
        chk(req, "latency", lat, exp_lat);
        if (!wr) chk(req, "read data", rd, exp_rd);
    endtask

    initial begin
        int budget;
        budget = 0;
        forever begin
            @(posedge clk);
            budget++;
            if (budget > 150000) begin
                n_err++;
                $display("FAIL watchdog: run did not complete");
                $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        int t_rd, t_rdx, t_fl;
        for (int c = 0; c < 2; c++) begin
            rq_v[c] = 0; rq_w[c] = 0; rq_a[c] = '0; rq_d[c] = '0;
        end
        for (int a = 0; a < NADDR; a++) gm[a] = init_val(a);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "ready0", rdy[0], 1); chk("R1", "ready1", rdy[1], 1);
        chk("R1", "bus_req0", breq[0], 0); chk("R1", "flush0", fv[0], 0);

        // R4 read miss, R3 shared hit and upgrade, R2 owned hits
        run(0, 0, 5, 0, init_val(5), 3, "R4");
        chk("R4", "shared reads", n_rd[0], 1);
        run(0, 0, 5, 0, init_val(5), 2, "R3");
        run(0, 1, 5, 16'hA5A5, 0, 3, "R3");
        chk("R3", "upgrade exclusive reads", n_rdx[0], 1);
        run(0, 1, 5, 16'h0B0B, 0, 2, "R2");
        run(0, 0, 5, 0, 16'h0B0B, 2, "R2");
        chk("R2", "no bus traffic", n_rd[0] + n_rdx[0], 2);

        // R5 shared read snoop of owned line
        run(1, 0, 5, 0, 16'h0B0B, 3, "R5");
        chk("R5", "flush count", n_fl[0], 1); chk("R5", "flush data", last_fl[0], 16'h0B0B);
        run(0, 0, 5, 0, 16'h0B0B, 2, "R5");
        run(1, 0, 5, 0, 16'h0B0B, 2, "R5");

        // R7 exclusive read snoop of shared line
        run(1, 1, 5, 16'h0C0C, 0, 3, "R7");
        chk("R7", "no flush", n_fl[0], 1);
        run(0, 0, 5, 0, 16'h0C0C, 3, "R7");
        chk("R5", "peer flush", last_fl[1], 16'h0C0C);
        t_fl = n_fl[1];
        run(0, 1, 5, 16'h0D0D, 0, 3, "R7");
        chk("R7", "shared peer silent", n_fl[1], t_fl);

        // R6 exclusive read snoop of owned line
        run(1, 1, 5, 16'h0E0E, 0, 3, "R6");
        chk("R6", "flush count", n_fl[0], 2); chk("R6", "flush data", last_fl[0], 16'h0D0D);
        run(0, 0, 5, 0, 16'h0E0E, 3, "R6");

        // R7 shared stays shared under shared read
        run(1, 0, 9, 0, init_val(9), 3, "R7");
        t_fl = n_fl[1];
        run(0, 0, 9, 0, init_val(9), 3, "R7");
        chk("R7", "no flush from shared", n_fl[1], t_fl);
        run(1, 0, 9, 0, init_val(9), 2, "R7");

        // R8 snoop with differing tag
        run(1, 1, 4, 16'h0F0F, 0, 3, "R8");
        t_fl = n_fl[1];
        run(0, 0, 8, 0, init_val(8), 3, "R8");
        chk("R8", "no flush on tag miss", n_fl[1], t_fl);
        run(1, 0, 4, 0, 16'h0F0F, 2, "R8");

        // R9 dirty victim written back before fill, R10 latencies
        run(0, 1, 12, 16'h1212, 0, 3, "R9");
        t_rd = n_rd[0];
        run(0, 0, 28, 0, init_val(28), 4, "R9");
        chk("R9", "writeback count", n_wb[0], 1);
        chk("R9", "writeback addr", last_wba[0], 12);
        chk("R9", "writeback data", last_wbd[0], 16'h1212);
        chk("R9", "writeback before fill", wb_cyc[0] < fill_cyc[0], 1);
        chk("R9", "fill issued", n_rd[0], t_rd + 1);
        t_fl = n_fl[0];
        run(1, 0, 12, 0, 16'h1212, 4, "R10");
        chk("R9", "peer writeback addr", last_wba[1], 4);
        chk("R9", "peer writeback data", last_wbd[1], 16'h0F0F);
        chk("R9", "evicted line silent", n_fl[0], t_fl);
        gm[5] = 16'h0E0E; gm[4] = 16'h0F0F; gm[12] = 16'h1212;

        // R12 sequential sweep over conflicting addresses
        for (int i = 0; i < 400; i++) begin
            int c, a;
            logic wr;
            logic [DW-1:0] wd, rd;
            int lat;
            c  = (i / 2 + i / 7) % 2;
            a  = ((i * 13) % 5) * 4 + ((i / 3) % 2);
            wr = (i % 3 == 0);
            wd = DW'(i * 257 + 1);
            cpu_op(c, wr, AW'(a), wd, rd, lat);
            if (wr) gm[a] = wd;
            else chk("R12", "sweep read", rd, gm[a]);
        end

        // R12 concurrent requests, distinct addresses sharing indices
        for (int i = 0; i < 150; i++) begin
            int a0, a1, l0, l1;
            logic w0, w1;
            logic [DW-1:0] d0, d1, r0, r1;
            a0 = ((i * 3) % 6) * 4 + (i % 2);
            a1 = a0 + 4 + 4 * (i % 3);
            w0 = (i % 4 == 1); w1 = (i % 3 == 2);
            d0 = DW'(i * 97 + 5); d1 = DW'(i * 61 + 9);
            fork
                cpu_op(0, w0, AW'(a0), d0, r0, l0);
                cpu_op(1, w1, AW'(a1), d1, r1, l1);
            join
            if (w0) gm[a0] = d0; else chk("R12", "concurrent read 0", r0, gm[a0]);
            if (w1) gm[a1] = d1; else chk("R12", "concurrent read 1", r1, gm[a1]);
        end

        // R12 final cross-read of every touched address from both caches
        for (int a = 0; a < 40; a++) begin
            logic [DW-1:0] rd;
            int lat;
            cpu_op(a % 2, 1'b0, AW'(a), '0, rd, lat);
            chk("R12", "final read", rd, gm[a]);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule